// File: doc/BRIEF.md
# ADC Sample FIFO with Threshold Interrupt

This block buffers converted samples between a free-running ADC scan engine and a host that drains them with bus reads. The scan engine offers one 16-bit word per cycle on a push port. Each accepted host pop presents the oldest stored word on the cycle after the request. The FIFO holds 512 words. It keeps a 10-bit occupancy count and derives empty, half-full and full flags from that count.

The host programs a fill threshold and an enable bit. The block drives a level interrupt that stays high for as long as it is enabled and the count is at or above the threshold. No acknowledge is needed, because the line falls as soon as host pops bring the count below the threshold. A slot tag tells the host which position in the scan sequence the next word to be popped belongs to. The tag wraps at a scan length that the configuration sets.

Two clear inputs come from the control logic: one pulses when the system starts, the other when the scan setup is rewritten. Stopping the scan engine only stops pushes. Stored words stay poppable until the FIFO is empty or a clear arrives.

Top module: `smpl_fifo`

## Requirements
- R1: A push is accepted when `push_vld` is high, no clear is active, and the FIFO is not full or an accepted pop happens in the same cycle. Words leave in arrival order, and an accepted pop places the oldest word on `pop_data` at the clock edge that takes the request.
- R2: A pop while the count is 0 is ignored: the count and the internal pointers are unchanged and `pop_data` keeps its previous value.
- R3: An accepted push and an accepted pop in the same cycle leave the count unchanged. This includes the full case. On an empty FIFO, push plus pop accepts only the push, so the count becomes 1.
- R4: A push while full with no pop in the same cycle is dropped. The count stays at 512 and no stored word is overwritten.
- R5: `occ_count` ranges over 0..512. `fifo_full` is high exactly when the count is 512, which is bit 9 of the count. `fifo_half` is high when the count is 256 or more. `fifo_empty` is high when the count is 0.
- R6: The interrupt threshold resets to 256. A cycle with `thr_wr` high loads it from `thr_data`.
- R7: `irq` is high exactly when the enable is set and the count is at or above the threshold. It follows count changes in the same cycle the count changes and falls by itself once pops take the count below the threshold.
- R8: The interrupt enable resets to 0. A cycle with `irq_en_wr` high loads it from `irq_en_data`. With the enable at 0, `irq` stays low at any count.
- R9: `head_slot` resets to 0 and is unchanged by anything other than an accepted pop or a clear. Each accepted pop advances it by one. A pop taken while it equals `slot_limit` returns it to 0.
- R10: `sys_start` or `cfg_clear` empties the FIFO and sets the count and `head_slot` to 0 at the next edge. A push or pop in the same cycle is discarded, and `pop_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_vld | input | 1 | Scan engine offers a word |
| push_data | input | 16 | Word from the scan engine |
| pop_req | input | 1 | Host read of the FIFO |
| pop_data | output | 16 | Word taken by the last accepted pop |
| sys_start | input | 1 | System start pulse, clears the FIFO |
| cfg_clear | input | 1 | Scan setup rewritten, clears the FIFO |
| slot_limit | input | 5 | Last slot index of one scan |
| thr_wr | input | 1 | Load the interrupt threshold |
| thr_data | input | 10 | New threshold value |
| irq_en_wr | input | 1 | Load the interrupt enable |
| irq_en_data | input | 1 | New interrupt enable value |
| occ_count | output | 10 | Number of stored words |
| fifo_empty | output | 1 | Count is 0 |
| fifo_full | output | 1 | Count is 512 |
| fifo_half | output | 1 | Count is 256 or more |
| head_slot | output | 5 | Scan slot of the next word to pop |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 512 words of 16 bits and a 5-bit slot tag. At that depth a fill of a few hundred cycles reaches the 255/256 boundary of the half flag and the default threshold, as well as the full boundary at 512. It therefore exercises the dropped push and the full push-with-pop against the real sizes, not a scaled-down copy. Slot limits of 2 and 1 are both used, so the tag wrap is seen at two scan lengths.

// File: rtl/smpl_fifo_pkg.sv
// Package: shared encodings for the sample FIFO.
// Assumes: nothing beyond standard SystemVerilog.
package smpl_fifo_pkg;

    // Operation applied to the occupancy counter in one cycle.
    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_INC  = 2'd1,
        OCC_DEC  = 2'd2,
        OCC_CLR  = 2'd3
    } occ_op_e;

    // Default geometry used by the top level.
    localparam int DEF_DEPTH  = 512;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_TAG_W  = 5;

endpackage

// File: rtl/smpl_fifo_store.sv
// Module: word storage with read/write pointers and a registered read port.
// Assumes: DEPTH is a power of two, so the pointers wrap naturally; the caller
// never asserts wr_en when full without rd_en, nor rd_en when empty.
module smpl_fifo_store #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;

    // Write port: store the pushed word at the tail.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer update: advance on access, rewind on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + AW'(1);
            if (rd_en) rd_ptr <= rd_ptr + AW'(1);
        end
    end

    // Read register: capture the head word on an accepted pop, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_ptr];
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R2

endmodule

// File: rtl/smpl_fifo_occ.sv
// Module: occupancy counter and the flags derived from it.
// Assumes: the caller never requests OCC_INC at DEPTH or OCC_DEC at zero.
module smpl_fifo_occ
    import smpl_fifo_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  occ_op_e                    op,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full,
    output logic                       half
);
    localparam int              CW      = $clog2(DEPTH+1);
    localparam logic [CW-1:0]   DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0]   HALF_C  = CW'(DEPTH / 2);
    localparam bit              POW2    = (DEPTH & (DEPTH - 1)) == 0;

    // Counter: apply the operation chosen by the top level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case (op)
                OCC_INC: count <= count + CW'(1);
                OCC_DEC: count <= count - CW'(1);
                OCC_CLR: count <= '0;
                default: count <= count;
            endcase
        end
    end

    // Empty and half flags from magnitude compares.
    always_comb begin
        empty = (count == '0);
        half  = (count >= HALF_C);
    end

    // Full flag: top bit alone for power-of-two depths, full compare otherwise.
    generate
        if (POW2) begin : g_full_bit
            assign full = count[CW-1];
        end else begin : g_full_cmp
            assign full = (count == DEPTH_C);
        end
    endgenerate

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C); // R5
    AST_FULL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half); // R5

endmodule

// File: rtl/smpl_fifo_irq.sv
// Module: threshold and enable registers plus the level interrupt.
// Assumes: count is the registered occupancy; irq follows it in the same cycle.
module smpl_fifo_irq #(
    parameter int CW      = 10,
    parameter int DEF_THR = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thr_wr,
    input  logic [CW-1:0] thr_data,
    input  logic          en_wr,
    input  logic          en_data,
    input  logic [CW-1:0] count,
    output logic          irq
);
    logic [CW-1:0] thr_q;
    logic          en_q;

    // Host-written threshold, reset to the half-full level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= CW'(DEF_THR);
        end else if (thr_wr) begin
            thr_q <= thr_data;
        end
    end

    // Host-written enable, reset to disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= en_data;
        end
    end

    // Level output: no latch, it drops as soon as the count falls short.
    always_comb begin
        irq = en_q && (count >= thr_q);
    end

    AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && $stable(en_q) && $stable(thr_q) && (count >= $past(count))) |-> irq); // R7
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_data) |=> !irq); // R8

endmodule

// File: rtl/smpl_fifo_head.sv
// Module: scan-slot tag of the word at the head of the FIFO.
// Assumes: limit is held steady while words are queued; a change of scan setup
// is accompanied by a clear.
module smpl_fifo_head #(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [TAG_W-1:0] limit,
    output logic [TAG_W-1:0] head
);
    // Tag counter: step per pop, wrap after the last slot, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            head <= '0;
        end else if (adv) begin
            if (head == limit) head <= '0;
            else               head <= head + TAG_W'(1);
        end
    end

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(head)); // R9
    AST_HEAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (head == '0)); // R10

endmodule

// File: rtl/smpl_fifo.sv
// Module: sample FIFO top. Arbitrates push, pop and clear, and ties together
// the storage, occupancy counter, interrupt unit and slot tag.
// Assumes: sys_start and cfg_clear are single-cycle pulses from control logic;
// DEPTH is a power of two.
module smpl_fifo
    import smpl_fifo_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int DATA_W = DEF_DATA_W,
    parameter int TAG_W  = DEF_TAG_W,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_vld,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    input  logic              sys_start,
    input  logic              cfg_clear,
    input  logic [TAG_W-1:0]  slot_limit,
    input  logic              thr_wr,
    input  logic [CW-1:0]     thr_data,
    input  logic              irq_en_wr,
    input  logic              irq_en_data,
    output logic [CW-1:0]     occ_count,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_half,
    output logic [TAG_W-1:0]  head_slot,
    output logic              irq
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic    clr;
    logic    pop_ok;
    logic    push_ok;
    occ_op_e occ_op;

    // Arbitration: clear wins, pops need data, pushes need room or a pop.
    always_comb begin
        clr     = sys_start | cfg_clear;
        pop_ok  = pop_req & ~fifo_empty & ~clr;
        push_ok = push_vld & (~fifo_full | pop_ok) & ~clr;
        if (clr)                    occ_op = OCC_CLR;
        else if (push_ok && !pop_ok) occ_op = OCC_INC;
        else if (pop_ok && !push_ok) occ_op = OCC_DEC;
        else                         occ_op = OCC_HOLD;
    end

    smpl_fifo_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (push_ok),
        .wr_data (push_data),
        .rd_en   (pop_ok),
        .rd_data (pop_data)
    );

    smpl_fifo_occ #(
        .DEPTH (DEPTH)
    ) occ_i (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (occ_op),
        .count (occ_count),
        .empty (fifo_empty),
        .full  (fifo_full),
        .half  (fifo_half)
    );

    smpl_fifo_irq #(
        .CW      (CW),
        .DEF_THR (DEPTH / 2)
    ) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_wr   (thr_wr),
        .thr_data (thr_data),
        .en_wr    (irq_en_wr),
        .en_data  (irq_en_data),
        .count    (occ_count),
        .irq      (irq)
    );

    smpl_fifo_head #(
        .TAG_W (TAG_W)
    ) head_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (pop_ok),
        .limit (slot_limit),
        .head  (head_slot)
    );

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && push_vld && !pop_req && !sys_start && !cfg_clear) |=> (occ_count == DEPTH_C)); // R4
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && pop_req && !push_vld) |=> fifo_empty); // R2
    AST_SAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_empty && push_vld && pop_req && !sys_start && !cfg_clear) |=> $stable(occ_count)); // R3
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_start || cfg_clear) |=> (fifo_empty && $stable(pop_data))); // R10

endmodule

// File: tb/smpl_fifo_tb_top.sv
module smpl_fifo_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_vld;
    logic [15:0] push_data;
    logic        pop_req;
    logic [15:0] pop_data;
    logic        sys_start;
    logic        cfg_clear;
    logic [4:0]  slot_limit;
    logic        thr_wr;
    logic [9:0]  thr_data;
    logic        irq_en_wr;
    logic        irq_en_data;
    logic [9:0]  occ_count;
    logic        fifo_empty;
    logic        fifo_full;
    logic        fifo_half;
    logic [4:0]  head_slot;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    smpl_fifo dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_vld    (push_vld),
        .push_data   (push_data),
        .pop_req     (pop_req),
        .pop_data    (pop_data),
        .sys_start   (sys_start),
        .cfg_clear   (cfg_clear),
        .slot_limit  (slot_limit),
        .thr_wr      (thr_wr),
        .thr_data    (thr_data),
        .irq_en_wr   (irq_en_wr),
        .irq_en_data (irq_en_data),
        .occ_count   (occ_count),
        .fifo_empty  (fifo_empty),
        .fifo_full   (fifo_full),
        .fifo_half   (fifo_half),
        .head_slot   (head_slot),
        .irq         (irq)
    );

    typedef struct packed {
        logic        push;
        logic        pop;
        logic [15:0] din;
        logic [9:0]  cnt;
        logic [15:0] dout;
        logic [4:0]  head;
    } vec_t;

    // Walked with slot_limit = 2 from an empty FIFO.
    localparam vec_t VECS [12] = '{
        '{1'b1, 1'b0, 16'hA001, 10'd1, 16'h0000, 5'd0},
        '{1'b1, 1'b0, 16'hA002, 10'd2, 16'h0000, 5'd0},
        '{1'b1, 1'b0, 16'hA003, 10'd3, 16'h0000, 5'd0},
        '{1'b0, 1'b1, 16'h0000, 10'd2, 16'hA001, 5'd1},
        '{1'b1, 1'b1, 16'hA004, 10'd2, 16'hA002, 5'd2},
        '{1'b0, 1'b1, 16'h0000, 10'd1, 16'hA003, 5'd0},
        '{1'b0, 1'b1, 16'h0000, 10'd0, 16'hA004, 5'd1},
        '{1'b0, 1'b1, 16'h0000, 10'd0, 16'hA004, 5'd1},
        '{1'b1, 1'b1, 16'hA005, 10'd1, 16'hA004, 5'd1},
        '{1'b0, 1'b1, 16'h0000, 10'd0, 16'hA005, 5'd2},
        '{1'b0, 1'b0, 16'h0000, 10'd0, 16'hA005, 5'd2},
        '{1'b1, 1'b0, 16'hA006, 10'd1, 16'hA005, 5'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        push_vld = 0; push_data = '0; pop_req = 0; sys_start = 0; cfg_clear = 0;
        thr_wr = 0; thr_data = '0; irq_en_wr = 0; irq_en_data = 0;
    endtask

    // Drive one cycle of push/pop, pass one rising edge, return at the falling edge.
    task automatic cyc(input logic p, input logic [15:0] d, input logic q);
        push_vld = p; push_data = d; pop_req = q;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic pulse_clear(input bit start, input bit pushing);
        sys_start = start; cfg_clear = !start; push_vld = pushing; push_data = 16'h7777;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        slot_limit = 5'd2;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        chk("R5 reset count", 32'(occ_count), 0);
        chk("R5 reset empty", 32'(fifo_empty), 1);
        chk("R5 reset full", 32'(fifo_full), 0);
        chk("R5 reset half", 32'(fifo_half), 0);
        chk("R9 reset head", 32'(head_slot), 0);
        chk("R8 reset irq", 32'(irq), 0);
        chk("R1 reset pop_data", 32'(pop_data), 0);

        // Table walk: ordering, empty pop, simultaneous push and pop, slot tag
        foreach (VECS[i]) begin
            cyc(VECS[i].push, VECS[i].din, VECS[i].pop);
            chk($sformatf("R1/R2/R3 vec%0d count", i), 32'(occ_count), 32'(VECS[i].cnt));
            chk($sformatf("R1/R2/R3 vec%0d pop_data", i), 32'(pop_data), 32'(VECS[i].dout));
            chk($sformatf("R9 vec%0d head", i), 32'(head_slot), 32'(VECS[i].head));
        end

        // Configuration clear
        pulse_clear(1'b0, 1'b1);
        chk("R10 cfg_clear count", 32'(occ_count), 0);
        chk("R10 cfg_clear head", 32'(head_slot), 0);
        chk("R10 cfg_clear pop_data held", 32'(pop_data), 32'h A005);
        cyc(1'b0, 16'h0, 1'b1);
        chk("R2 pop after clear", 32'(pop_data), 32'hA005);

        // Fill to full with interrupt enabled at default threshold
        irq_en_wr = 1; irq_en_data = 1;
        @(negedge clk);
        idle_inputs();
        chk("R8 enabled empty irq", 32'(irq), 0);
        for (int i = 0; i < 512; i++) begin
            cyc(1'b1, 16'(i), 1'b0);
            if (i == 254) begin
                chk("R5 half at 255", 32'(fifo_half), 0);
                chk("R6 irq at 255", 32'(irq), 0);
            end
            if (i == 255) begin
                chk("R5 half at 256", 32'(fifo_half), 1);
                chk("R6/R7 irq at 256", 32'(irq), 1);
            end
            if (i == 510) chk("R5 full at 511", 32'(fifo_full), 0);
        end
        chk("R5 count 512", 32'(occ_count), 512);
        chk("R5 full 512", 32'(fifo_full), 1);
        cyc(1'b1, 16'hDEAD, 1'b0);
        chk("R4 dropped push count", 32'(occ_count), 512);
        cyc(1'b1, 16'hBEEF, 1'b1);
        chk("R3 full push+pop count", 32'(occ_count), 512);
        chk("R1 first word", 32'(pop_data), 0);
        for (int i = 1; i < 512; i++) begin
            cyc(1'b0, 16'h0, 1'b1);
            chk("R1/R4 drain order", 32'(pop_data), 32'(i));
            if (occ_count == 10'd256) chk("R7 irq at 256", 32'(irq), 1);
            if (occ_count == 10'd255) chk("R7 irq drop at 255", 32'(irq), 0);
        end
        cyc(1'b0, 16'h0, 1'b1);
        chk("R3 word pushed while full", 32'(pop_data), 32'hBEEF);
        chk("R5 empty after drain", 32'(fifo_empty), 1);
        cyc(1'b0, 16'h0, 1'b1);
        chk("R2 empty pop holds", 32'(pop_data), 32'hBEEF);
        chk("R2 empty pop count", 32'(occ_count), 0);

        // Programmed threshold
        thr_wr = 1; thr_data = 10'd3;
        @(negedge clk);
        idle_inputs();
        cyc(1'b1, 16'h0101, 1'b0);
        cyc(1'b1, 16'h0102, 1'b0);
        chk("R6 irq below new threshold", 32'(irq), 0);
        cyc(1'b1, 16'h0103, 1'b0);
        chk("R6 irq at new threshold", 32'(irq), 1);
        cyc(1'b0, 16'h0, 1'b1);
        chk("R7 irq falls after pop", 32'(irq), 0);
        cyc(1'b1, 16'h0104, 1'b0);
        chk("R7 irq rises again", 32'(irq), 1);
        irq_en_wr = 1; irq_en_data = 0;
        @(negedge clk);
        idle_inputs();
        chk("R8 disabled irq", 32'(irq), 0);
        chk("R8 disable keeps count", 32'(occ_count), 3);

        // System start clears, push in same cycle discarded
        pulse_clear(1'b1, 1'b1);
        chk("R10 start count", 32'(occ_count), 0);
        chk("R10 start empty", 32'(fifo_empty), 1);
        chk("R10 start head", 32'(head_slot), 0);

        // Slot wrap at limit 1
        slot_limit = 5'd1;
        pulse_clear(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b1, 16'(16'h0200 + i), 1'b0);
        cyc(1'b0, 16'h0, 1'b1);
        chk("R9 head after pop1", 32'(head_slot), 1);
        chk("R1 pop1 data", 32'(pop_data), 32'h0200);
        cyc(1'b0, 16'h0, 1'b1);
        chk("R9 head wraps", 32'(head_slot), 0);
        chk("R1 pop2 data", 32'(pop_data), 32'h0201);
        cyc(1'b0, 16'h0, 1'b0);
        chk("R9 head idle", 32'(head_slot), 0);
        cyc(1'b0, 16'h0, 1'b1);
        chk("R9 head after pop3", 32'(head_slot), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule